// File: doc/BRIEF.md
# Weighted-Sum Neuron with Selectable Transfer Stage

This block computes the response of one artificial neuron. A vector of unsigned 8-bit inputs arrives in parallel with a valid strobe. The block scales each element by its own signed 8-bit coefficient, adds the products to a programmable signed bias, and passes the total through a transfer stage. The transfer stage is either a hard decision or a shift-and-clip that fits the value into 0..255. An inhibit line that is captured with the vector blocks the neuron and forces its result to zero.

All products go through one shared multiplier, one element per cycle. A small state machine steps through the elements. Its states are ST_IDLE (waiting for a vector), ST_MAC (one product accumulated per cycle), ST_SCALE (transfer result registered) and ST_EMIT (result driven out). The transitions are as follows:
- ST_IDLE goes to ST_MAC when a vector is accepted.
- ST_MAC goes to ST_SCALE after the last element.
- ST_SCALE always goes to ST_EMIT.
- ST_EMIT always returns to ST_IDLE.

Coefficients are written through a one-slot-per-cycle write port.

Top module: `neuron_core`

## Requirements
- R1: After reset `out_valid` is 0, `busy` is 0 and `out_value` is 0.
- R2: The weighted sum is the sum over i of `in_vec[8i+7:8i]` (unsigned) times coefficient slot i (two's-complement signed, may be negative).
- R3: The signed `bias` is added to the weighted sum before the transfer stage.
- R4: With `mode_sel` = 0 (decision mode) the result is 255 when the biased sum is greater than 0, and 0 otherwise, including a sum of exactly 0.
- R5: With `mode_sel` = 1 (linear mode) the biased sum is arithmetically shifted right by `shift_amt`. The result is then clipped to 0 when negative and to 255 when above 255.
- R6: When `inhibit` is 1 in the accept cycle, the result is 0 whatever the sum and mode are.
- R7: `out_valid` rises exactly N_INPUTS+2 clock edges after the accept edge, and it is high for one cycle only.
- R8: A vector is accepted only when `busy` is 0. `busy` is 1 from the edge after acceptance until the result is presented. A strobe raised while `busy` is 1 is ignored and does not change the result.
- R9: A write with `wt_we` = 1 stores `wt_data` into slot `wt_addr`. The new coefficient is used for vectors accepted afterwards, and the other slots are left unchanged.
- R10: `mode_sel`, `shift_amt`, `bias`, `inhibit` and `in_vec` are all captured at the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_we | input | 1 | Coefficient write strobe |
| wt_addr | input | IDX_W | Coefficient slot to write |
| wt_data | input | WT_W | Signed coefficient value |
| in_valid | input | 1 | Input vector strobe |
| in_vec | input | N_INPUTS*IN_W | Packed unsigned inputs, element i at bits [IN_W*i +: IN_W] |
| inhibit | input | 1 | Forces the result to 0 when captured as 1 |
| mode_sel | input | 1 | 0 = decision, 1 = linear shift-and-clip |
| shift_amt | input | SH_W | Right-shift count for linear mode |
| bias | input | BIAS_W | Signed bias added to the sum |
| busy | output | 1 | Neuron is processing a vector |
| out_valid | output | 1 | One-cycle result strobe |
| out_value | output | OUT_W | Result, held until the next one |

## Verification
The bench builds the block with its default parameters: four inputs, 8-bit inputs and coefficients, a 16-bit bias and a 4-bit shift. Four slots are few enough that each one is rewritten often, both singly and all together. Four elements at full scale (255 × 127 each) drive the sum far past 255 and, with −128 coefficients, far below zero. Both clip edges and the exact-zero decision point are therefore reachable. Random vectors also inject strobes while the block is busy and change the coefficients between runs.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MAC   = 2'd1,
        ST_SCALE = 2'd2,
        ST_EMIT  = 2'd3
    } nstate_t;

    typedef enum logic {
        XF_THRESH = 1'b0,
        XF_LINEAR = 1'b1
    } xfer_t;

endpackage

// File: rtl/neuron_weight_bank.sv
module neuron_weight_bank #(
    parameter int N_SLOTS = 4,
    parameter int WT_W    = 8,
    parameter int AW      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic signed [WT_W-1:0]  wdata,
    input  logic [AW-1:0]           raddr,
    output logic signed [WT_W-1:0]  rdata
);

    logic [N_SLOTS-1:0][WT_W-1:0] slot_q;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && (waddr == AW'(g)))
                slot_q[g] <= wdata;
        end
    end

    assign rdata = $signed(slot_q[raddr]);

endmodule

// File: rtl/neuron_mac.sv
module neuron_mac #(
    parameter int IN_W   = 8,
    parameter int WT_W   = 8,
    parameter int BIAS_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic signed [BIAS_W-1:0]  bias,
    input  logic                      step,
    input  logic [IN_W-1:0]           x,
    input  logic signed [WT_W-1:0]    w,
    output logic signed [ACC_W-1:0]   acc
);

    localparam int PROD_W = IN_W + WT_W + 1;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod = $signed({1'b0, x}) * w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clear)
            acc <= ACC_W'(bias);
        else if (step)
            acc <= acc + ACC_W'(prod);
    end

endmodule

// File: rtl/neuron_transfer.sv
module neuron_transfer
    import neuron_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int SH_W  = 4,
    parameter int OUT_W = 8
) (
    input  logic signed [ACC_W-1:0] sum,
    input  xfer_t                   mode,
    input  logic [SH_W-1:0]         shift,
    output logic [OUT_W-1:0]        y
);

    localparam logic signed [ACC_W-1:0] LIMIT = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        shifted = sum >>> shift;
        y       = '0;
        unique case (mode)
            XF_THRESH: y = (sum > 0) ? '1 : '0;
            XF_LINEAR: begin
                if (shifted < 0)
                    y = '0;
                else if (shifted > LIMIT)
                    y = '1;
                else
                    y = shifted[OUT_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/neuron_core.sv
module neuron_core
    import neuron_pkg::*;
#(
    parameter int N_INPUTS = 4,
    parameter int IN_W     = 8,
    parameter int WT_W     = 8,
    parameter int BIAS_W   = 16,
    parameter int SH_W     = 4,
    parameter int OUT_W    = 8,
    localparam int IDX_W   = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1,
    localparam int PROD_W  = IN_W + WT_W + 1,
    localparam int BASE_W  = (PROD_W > BIAS_W) ? PROD_W : BIAS_W,
    localparam int ACC_W   = BASE_W + IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wt_we,
    input  logic [IDX_W-1:0]            wt_addr,
    input  logic signed [WT_W-1:0]      wt_data,
    input  logic                        in_valid,
    input  logic [N_INPUTS*IN_W-1:0]    in_vec,
    input  logic                        inhibit,
    input  logic                        mode_sel,
    input  logic [SH_W-1:0]             shift_amt,
    input  logic signed [BIAS_W-1:0]    bias,
    output logic                        busy,
    output logic                        out_valid,
    output logic [OUT_W-1:0]            out_value
);

    nstate_t                  state_q, state_d;
    logic [IDX_W-1:0]         idx_q;
    logic [N_INPUTS*IN_W-1:0] vec_q;
    logic                     inh_q;
    xfer_t                    mode_q;
    logic [SH_W-1:0]          shift_q;
    logic signed [BIAS_W-1:0] bias_q;
    logic [OUT_W-1:0]         res_q;

    logic                     accept;
    logic                     last_elem;
    logic [IN_W-1:0]          x_cur;
    logic signed [WT_W-1:0]   w_cur;
    logic signed [ACC_W-1:0]  acc;
    logic [OUT_W-1:0]         xfer_y;

    assign accept    = in_valid && (state_q == ST_IDLE);
    assign last_elem = (idx_q == IDX_W'(N_INPUTS - 1));
    assign x_cur     = vec_q[int'(idx_q)*IN_W +: IN_W];
    assign busy      = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_MAC;
            ST_MAC:   if (last_elem) state_d = ST_SCALE;
            ST_SCALE:                state_d = ST_EMIT;
            ST_EMIT:                 state_d = ST_IDLE;
        endcase
    end

    // Captured operands and element index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            vec_q   <= '0;
            inh_q   <= 1'b0;
            mode_q  <= XF_THRESH;
            shift_q <= '0;
            bias_q  <= '0;
            res_q   <= '0;
        end else begin
            if (accept) begin
                idx_q   <= '0;
                vec_q   <= in_vec;
                inh_q   <= inhibit;
                mode_q  <= xfer_t'(mode_sel);
                shift_q <= shift_amt;
                bias_q  <= bias;
            end else if (state_q == ST_MAC && !last_elem) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_SCALE)
                res_q <= xfer_y;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= (state_q == ST_EMIT);
            if (state_q == ST_EMIT)
                out_value <= inh_q ? '0 : res_q;
        end
    end

    neuron_weight_bank #(
        .N_SLOTS (N_INPUTS),
        .WT_W    (WT_W),
        .AW      (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wt_we),
        .waddr (wt_addr),
        .wdata (wt_data),
        .raddr (idx_q),
        .rdata (w_cur)
    );

    neuron_mac #(
        .IN_W   (IN_W),
        .WT_W   (WT_W),
        .BIAS_W (BIAS_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .bias  (bias),
        .step  (state_q == ST_MAC),
        .x     (x_cur),
        .w     (w_cur),
        .acc   (acc)
    );

    neuron_transfer #(
        .ACC_W (ACC_W),
        .SH_W  (SH_W),
        .OUT_W (OUT_W)
    ) u_xfer (
        .sum   (acc),
        .mode  (mode_q),
        .shift (shift_q),
        .y     (xfer_y)
    );

endmodule

// File: rtl/neuron_core_check.sv
module neuron_core_check
    import neuron_pkg::*;
#(
    parameter int N_INPUTS = 4,
    parameter int OUT_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_value,
    input logic             inh_q,
    input xfer_t            mode_q
);

    localparam int CW = $clog2(N_INPUTS + 4) + 1;

    logic [CW-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (in_valid && !busy)
            lat_q <= CW'(1);
        else if (busy)
            lat_q <= lat_q + 1'b1;
    end

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == CW'(N_INPUTS + 3)));

    assert_inhibit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && inh_q) |-> (out_value == '0));

    assert_decision_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == XF_THRESH) |-> (out_value == '0 || out_value == '1));

endmodule

bind neuron_core neuron_core_check #(
    .N_INPUTS (N_INPUTS),
    .OUT_W    (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_value (out_value),
    .inh_q     (inh_q),
    .mode_q    (mode_q)
);

// File: tb/neuron_core_test.sv
module neuron_core_test;

    localparam int N = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wt_we = 1'b0;
    logic [1:0]       wt_addr = '0;
    logic [7:0]       wt_data = '0;
    logic             in_valid = 1'b0;
    logic [N*8-1:0]   in_vec = '0;
    logic             inhibit = 1'b0;
    logic             mode_sel = 1'b0;
    logic [3:0]       shift_amt = '0;
    logic [15:0]      bias = '0;
    logic             busy;
    logic             out_valid;
    logic [7:0]       out_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int wm [N];
    int xv [N];

    always #5 clk = ~clk;

    neuron_core #(.N_INPUTS(N)) uut (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr),
        .wt_data(wt_data), .in_valid(in_valid), .in_vec(in_vec),
        .inhibit(inhibit), .mode_sel(mode_sel), .shift_amt(shift_amt),
        .bias(bias), .busy(busy), .out_valid(out_valid), .out_value(out_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int b, input int md, input int sh, input int inh);
        int s = b;
        int t;
        for (int i = 0; i < N; i++) s += xv[i] * wm[i];
        if (inh != 0) return 0;
        if (md == 0) return (s > 0) ? 255 : 0;
        t = s >>> sh;
        if (t < 0) return 0;
        if (t > 255) return 255;
        return t;
    endfunction

    task automatic write_wt(input int slot, input int val);
        @(negedge clk);
        wt_we = 1'b1; wt_addr = 2'(slot); wt_data = 8'(val);
        @(negedge clk);
        wt_we = 1'b0;
        wm[slot] = val;
    endtask

    task automatic run(input string req, input int b, input int md, input int sh,
                       input int inh, input bit inject);
        int lat = 0;
        int exp = model(b, md, sh, inh);
        @(negedge clk);
        for (int i = 0; i < N; i++) in_vec[i*8 +: 8] = 8'(xv[i]);
        bias = 16'(b); mode_sel = md[0]; shift_amt = 4'(sh); inhibit = inh[0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 busy after accept", int'(busy), 1);
        while (!out_valid && lat < 40) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 1) begin
                in_valid = 1'b1; in_vec = ~in_vec; bias = ~bias; inhibit = ~inhibit;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        check("R7 latency", lat, N + 2);
        check(req, int'(out_value), exp);
        @(negedge clk);
        check("R7 single pulse", int'(out_valid), 0);
        check("R8 idle after result", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin wm[i] = 0; xv[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 out_valid at reset", int'(out_valid), 0);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 out_value at reset", int'(out_value), 0);
        rst_n = 1'b1;

        // R9 weight slots, signed values
        write_wt(0, 10); write_wt(1, -20); write_wt(2, 30); write_wt(3, -128);
        xv = '{1, 1, 1, 0};
        run("R2 signed sum linear", 0, 1, 0, 0, 0);              // 20
        xv = '{0, 3, 0, 1};
        run("R5 negative clips to 0", 0, 1, 0, 0, 0);            // -188
        xv = '{1, 1, 1, 0};
        run("R3 bias added", 100, 1, 0, 0, 0);                   // 120
        run("R4 sum zero gives 0", -20, 0, 0, 0, 0);
        run("R4 sum one gives 255", -19, 0, 0, 0, 0);
        run("R6 inhibit forces 0", 500, 0, 0, 1, 0);
        run("R10 R8 strobe while busy ignored", 100, 1, 0, 0, 1);

        for (int i = 0; i < N; i++) write_wt(i, 127);
        xv = '{255, 255, 255, 255};
        run("R5 high clip", 0, 1, 4, 0, 0);                      // 8096 -> 255
        run("R5 shift within range", 0, 1, 9, 0, 0);             // 253
        write_wt(3, -128);
        run("R9 single slot rewrite", 0, 1, 9, 0, 0);

        for (int r = 0; r < 150; r++) begin
            if (r % 8 == 0)
                for (int i = 0; i < N; i++) write_wt(i, int'($signed(8'($urandom))));
            for (int i = 0; i < N; i++) xv[i] = int'($urandom_range(255, 0));
            run("R2 R5 random vector",
                int'($signed(16'($urandom_range(65535, 0)))) / 4,
                int'($urandom_range(1, 0)), int'($urandom_range(15, 0)),
                ($urandom_range(7, 0) == 0) ? 1 : 0,
                $urandom_range(3, 0) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule